// File: doc/BRIEF.md
# Radiation-Driven Mode Reconfiguration Controller

This controller selects one of three operating configurations for a reprogrammable computing fabric. The three configurations are parallel multi-processor, single-processor low power, and triple-redundant radiation tolerant. The choice follows a radiation-present signal from an external sensor and a low-power preference pin. When radiation is reported, the hardened triple-redundant configuration is required. Otherwise the preference pin decides between parallel and low power.

When the required configuration differs from the one running, the controller runs a fixed handover sequence. It first asks the running design to move its variables into hardened storage and waits for that to be confirmed. It then requests the external loader to bring up the new image. Once the loader reports completion, it signals the new design that its variables may be read back. The sensor pin is asynchronous, so it is synchronised and then filtered for stability, which stops a chattering sensor from causing repeated reconfiguration.

The save and reconfiguration exchanges are request/acknowledge pairs and carry no data stream, so they are plain control pins. Each request stays high until its acknowledge (or the save timeout) is seen. The loader may take any number of cycles; the controller simply holds its request and image index until the done pulse arrives.

Top module: `radmode_ctrl`

## Requirements
- R1: The wanted image index is 2 (radiation tolerant) whenever the filtered sensor reports radiation. With no radiation it is 1 (low power) when `lowpwr_pref_i` is 1, and 0 (parallel) when it is 0.
- R2: After reset, `cur_mode_o` is 2, all of `save_req_o`, `cfg_req_o`, `restore_o` and `save_err_o` are 0, and the filtered sensor level starts as radiation present.
- R3: `rad_raw_i` passes through a two-flop synchroniser. The synchronised level must differ from the filtered level for `STABLE_CYC` consecutive cycles before the filtered level changes. From a change on the pin to the rise of `save_req_o` is exactly `STABLE_CYC`+3 falling-edge samples, and shorter pulses have no effect.
- R4: When idle and the wanted index differs from `cur_mode_o`, `save_req_o` rises and stays high until `save_ack_i` is seen or the timeout expires. `cfg_req_o` stays low throughout the save phase.
- R5: After a save acknowledge, `cfg_req_o` goes high the next cycle. `cfg_img_o` carries the target index and stays stable until `cfg_done_i`.
- R6: On `cfg_done_i`, `cur_mode_o` takes the target index and `restore_o` pulses high for exactly one cycle. After that the controller is idle.
- R7: While a save or reconfiguration is in progress, changes of the sensor or preference do not alter the target image. After returning to idle, the wanted index is evaluated again and a new handover starts if it differs.
- R8: If no acknowledge arrives, `save_req_o` stays high for exactly `SAVE_TMO` cycles. Then `save_err_o` is set and `cfg_req_o` is forced anyway. `save_err_o` clears when the next handover begins.
- R9: While the wanted index equals `cur_mode_o`, no save request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rad_raw_i | input | 1 | Asynchronous radiation-present from sensor |
| lowpwr_pref_i | input | 1 | Prefer low power over parallel when no radiation |
| save_req_o | output | 1 | Request running design to save variables |
| save_ack_i | input | 1 | Save complete |
| cfg_req_o | output | 1 | Request loader to bring up image |
| cfg_img_o | output | 2 | Image index: 0 parallel, 1 low power, 2 radiation tolerant |
| cfg_done_i | input | 1 | Loader reports new image running |
| restore_o | output | 1 | One-cycle pulse: variables may be restored |
| save_err_o | output | 1 | Last save phase ended by timeout |
| cur_mode_o | output | 2 | Index of the running configuration |

## Verification
The bench measures the exact latency from a sensor edge to the save request. A filter that counts one cycle short, or that skips the synchroniser, shows up as a latency mismatch. Sensor pulses shorter than the stability window are applied repeatedly; a filter that does not reset its count on a return to the stable level would trigger a reconfiguration. The preference is flipped during a save to catch a design that retargets mid-handover instead of finishing and then starting a second handover. The save acknowledge is also withheld, to check the exact timeout length, the forced reconfiguration, and that the error flag clears at the next handover rather than sticking.

// File: rtl/radmode_pkg.sv
package radmode_pkg;
  typedef enum logic [1:0] {
    MODE_PAR  = 2'd0,
    MODE_LOWP = 2'd1,
    MODE_RADT = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAVE    = 2'd1,
    ST_LOAD    = 2'd2,
    ST_RESTORE = 2'd3
  } seq_st_t;
endpackage

// File: rtl/radmode_sync.sv
module radmode_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/radmode_filter.sv
module radmode_filter #(
  parameter int   STABLE_CYC = 16,
  parameter logic RST_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [CW-1:0] cnt;
  logic          filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      filt <= RST_VAL;
    end else if (lvl_i == filt) begin
      cnt <= '0;
    end else if (cnt == CW'(STABLE_CYC - 1)) begin
      cnt  <= '0;
      filt <= lvl_i;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lvl_o = filt;

  assert_filter_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ($past(cnt) == CW'(STABLE_CYC - 1)));
endmodule

// File: rtl/radmode_seq.sv
module radmode_seq
  import radmode_pkg::*;
#(
  parameter int SAVE_TMO = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mode_t      want_i,
  output logic       save_req_o,
  input  logic       save_ack_i,
  output logic       cfg_req_o,
  output logic [1:0] cfg_img_o,
  input  logic       cfg_done_i,
  output logic       restore_o,
  output logic       save_err_o,
  output logic [1:0] cur_mode_o
);
  localparam int TW = $clog2(SAVE_TMO + 1);

  seq_st_t       st;
  mode_t         tgt, cur;
  logic [TW-1:0] tmo_cnt;
  logic          err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tgt     <= MODE_RADT;
      cur     <= MODE_RADT;
      tmo_cnt <= '0;
      err     <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          tmo_cnt <= '0;
          if (want_i != cur) begin
            tgt <= want_i;
            err <= 1'b0;
            st  <= ST_SAVE;
          end
        end
        ST_SAVE: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (save_ack_i) begin
            st <= ST_LOAD;
          end else if (tmo_cnt == TW'(SAVE_TMO - 1)) begin
            err <= 1'b1;
            st  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cfg_done_i) begin
            cur <= tgt;
            st  <= ST_RESTORE;
          end
        end
        ST_RESTORE: st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  assign save_req_o = (st == ST_SAVE);
  assign cfg_req_o  = (st == ST_LOAD);
  assign restore_o  = (st == ST_RESTORE);
  assign cfg_img_o  = tgt;
  assign cur_mode_o = cur;
  assign save_err_o = err;

  assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_req_o, cfg_req_o, restore_o}));

  assert_save_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_o) |-> $past(save_req_o));

  assert_img_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && !cfg_done_i) |=> (cfg_req_o && $stable(cfg_img_o)));

  assert_restore_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> !restore_o);

  assert_tgt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req_o || cfg_req_o) |=> $stable(cfg_img_o));

  assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    save_req_o |-> (tmo_cnt < TW'(SAVE_TMO)));

  assert_err_on_tmo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_req_o) && !$past(save_ack_i)) |-> save_err_o);
endmodule

// File: rtl/radmode_ctrl.sv
module radmode_ctrl
  import radmode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 16,
  parameter int SAVE_TMO    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rad_raw_i,
  input  logic       lowpwr_pref_i,
  output logic       save_req_o,
  input  logic       save_ack_i,
  output logic       cfg_req_o,
  output logic [1:0] cfg_img_o,
  input  logic       cfg_done_i,
  output logic       restore_o,
  output logic       save_err_o,
  output logic [1:0] cur_mode_o
);
  logic  rad_s, rad_f;
  mode_t want;

  radmode_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rad_raw_i), .q_o(rad_s)
  );

  radmode_filter #(.STABLE_CYC(STABLE_CYC), .RST_VAL(1'b1)) u_filt (
    .clk(clk), .rst_n(rst_n), .lvl_i(rad_s), .lvl_o(rad_f)
  );

  always_comb begin
    if (rad_f)              want = MODE_RADT;
    else if (lowpwr_pref_i) want = MODE_LOWP;
    else                    want = MODE_PAR;
  end

  radmode_seq #(.SAVE_TMO(SAVE_TMO)) u_seq (
    .clk(clk), .rst_n(rst_n), .want_i(want),
    .save_req_o(save_req_o), .save_ack_i(save_ack_i),
    .cfg_req_o(cfg_req_o), .cfg_img_o(cfg_img_o), .cfg_done_i(cfg_done_i),
    .restore_o(restore_o), .save_err_o(save_err_o), .cur_mode_o(cur_mode_o)
  );

  assert_radt_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(save_req_o) && $past(rad_f)) |-> (cfg_img_o == 2'd2));
endmodule

// File: tb/radmode_ctrl_tb.sv
module radmode_ctrl_tb;
  localparam int STABLE_CYC = 16;
  localparam int SAVE_TMO   = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rad_raw_i = 1'b1;
  logic       lowpwr_pref_i = 1'b0;
  logic       save_ack_i = 1'b0;
  logic       cfg_done_i = 1'b0;
  logic       save_req_o, cfg_req_o, restore_o, save_err_o;
  logic [1:0] cfg_img_o, cur_mode_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  radmode_ctrl #(.STABLE_CYC(STABLE_CYC), .SAVE_TMO(SAVE_TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .rad_raw_i(rad_raw_i), .lowpwr_pref_i(lowpwr_pref_i),
    .save_req_o(save_req_o), .save_ack_i(save_ack_i),
    .cfg_req_o(cfg_req_o), .cfg_img_o(cfg_img_o), .cfg_done_i(cfg_done_i),
    .restore_o(restore_o), .save_err_o(save_err_o), .cur_mode_o(cur_mode_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // full handover with a bench-side loader model
  task automatic handover(input int exp_img, input int ack_dly, input bit tmo, input string tag);
    int n = 0;
    while (!save_req_o && n < 400) begin step(); n++; end
    chk(save_req_o == 1'b1, {tag, " R4 save request raised"}, save_req_o, 1);
    chk(save_err_o == 1'b0, {tag, " R8 error clear at handover start"}, save_err_o, 0);
    if (tmo) begin
      int k = 0;
      int bad = 0;
      while (save_req_o && k < 1000) begin
        if (cfg_req_o) bad++;
        step(); k++;
      end
      chk(k == SAVE_TMO, {tag, " R8 save phase length"}, k, SAVE_TMO);
      chk(bad == 0, {tag, " R4 no cfg request while saving"}, bad, 0);
      chk(save_err_o == 1'b1, {tag, " R8 timeout error"}, save_err_o, 1);
      chk(cfg_req_o == 1'b1, {tag, " R8 forced cfg request"}, cfg_req_o, 1);
    end else begin
      step(ack_dly);
      chk(save_req_o && !cfg_req_o, {tag, " R4 save held until ack"}, cfg_req_o, 0);
      save_ack_i = 1'b1;
      step();
      save_ack_i = 1'b0;
      chk(cfg_req_o && !save_req_o, {tag, " R5 cfg request after ack"}, cfg_req_o, 1);
    end
    chk(cfg_img_o == 2'(exp_img), {tag, " R1 image index"}, cfg_img_o, exp_img);
    step(3);
    chk(cfg_req_o && cfg_img_o == 2'(exp_img), {tag, " R5 request and image held"}, cfg_img_o, exp_img);
    cfg_done_i = 1'b1;
    step();
    cfg_done_i = 1'b0;
    chk(restore_o == 1'b1, {tag, " R6 restore pulse"}, restore_o, 1);
    chk(cur_mode_o == 2'(exp_img), {tag, " R6 current mode"}, cur_mode_o, exp_img);
    step();
    chk(restore_o == 1'b0, {tag, " R6 restore one cycle"}, restore_o, 0);
  endtask

  task automatic sc_reset();
    int hits = 0;
    step(2);
    chk(cur_mode_o == 2'd2, "R2 reset mode", cur_mode_o, 2);
    chk(!save_req_o && !cfg_req_o && !restore_o, "R2 requests idle", save_req_o, 0);
    chk(save_err_o == 1'b0, "R2 error clear", save_err_o, 0);
    for (int i = 0; i < 40; i++) begin step(); if (save_req_o) hits++; end
    chk(hits == 0, "R9 no handover when mode matches", hits, 0);
  endtask

  task automatic sc_clear_latency();
    int n = 0;
    rad_raw_i = 1'b0;
    lowpwr_pref_i = 1'b0;
    do begin step(); n++; end while (!save_req_o && n < 200);
    chk(n == STABLE_CYC + 3, "R3 sensor to save latency", n, STABLE_CYC + 3);
    handover(0, 3, 1'b0, "clear->parallel");
  endtask

  task automatic sc_chatter();
    int hits = 0;
    for (int p = 0; p < 5; p++) begin
      rad_raw_i = 1'b1;
      for (int i = 0; i < 10; i++) begin step(); if (save_req_o) hits++; end
      rad_raw_i = 1'b0;
      for (int i = 0; i < 10; i++) begin step(); if (save_req_o) hits++; end
    end
    step(30);
    chk(hits == 0 && !save_req_o, "R3 short pulses ignored", hits, 0);
    chk(cur_mode_o == 2'd0, "R3 mode unchanged by chatter", cur_mode_o, 0);
  endtask

  task automatic sc_busy_ignore();
    int n = 0;
    lowpwr_pref_i = 1'b1;
    while (!save_req_o && n < 50) begin step(); n++; end
    chk(save_req_o == 1'b1, "R1 preference starts handover", save_req_o, 1);
    lowpwr_pref_i = 1'b0;
    step(2);
    save_ack_i = 1'b1;
    step();
    save_ack_i = 1'b0;
    chk(cfg_img_o == 2'd1, "R7 target frozen during save", cfg_img_o, 1);
    step(2);
    cfg_done_i = 1'b1;
    step();
    cfg_done_i = 1'b0;
    chk(cur_mode_o == 2'd1, "R7 finished old target", cur_mode_o, 1);
    handover(0, 1, 1'b0, "R7 re-evaluate");
  endtask

  task automatic sc_timeout();
    rad_raw_i = 1'b1;
    handover(2, 0, 1'b1, "timeout->radt");
    rad_raw_i = 1'b0;
    handover(0, 2, 1'b0, "after timeout");
    chk(save_err_o == 1'b0, "R8 error stays clear after acked save", save_err_o, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    sc_reset();
    sc_clear_latency();
    sc_chatter();
    sc_busy_ignore();
    sc_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule